// File: doc/BRIEF.md
# Word-Granular Cache Vulnerability Tracker

This block is a passive monitor beside a write-back data cache. It observes cache events and keeps a running total of how many bit-cycles the data array spent holding data whose corruption by a single-bit upset would have mattered. The inputs are strobes for a line fill, a word read, a word write and a line eviction. The eviction strobe comes with the line's dirty status. The event inputs also carry a line index, a word index and the current value of a free-running cycle counter.

For each word the tracker keeps a last-access timestamp, a dirty flag and a valid flag. An interval opens when a word is filled, read or written. The event that closes it decides whether it counts. A read consumes the data, so its interval counts. An overwrite masks any earlier upset, so its interval does not count. An eviction writes back only modified words, so only dirty words count there. A counted interval adds its length times the word width to the total.

A parameter switches to a coarse line-level mode, in which any word access acts on every word of the line. Running both variants on the same event stream shows how far the coarse estimate drifts from the word-level one.

Top module: `word_vuln_tracker`

## Requirements
- R1: After reset the total is zero and every word is invalid and clean.
- R2: A read of a valid word adds (cycle − last access) × WORD_BITS to the total, visible one cycle after the strobe, and restarts that word's interval.
- R3: A write adds nothing. It restarts the written word's interval and marks that word dirty and valid.
- R4: A fill adds nothing. It restarts the interval of every word in the line, marks them valid and clears their dirty flags.
- R5: An eviction with dirty status high adds (cycle − last access) × WORD_BITS for each valid dirty word of the line, and nothing for clean words. Afterwards every word of the line is invalid and clean.
- R6: An eviction with dirty status low adds nothing and still invalidates the line.
- R7: A read of an invalid word (never filled, or evicted) adds nothing.
- R8: When several strobes are high in one cycle, only the highest-priority one acts: eviction, then fill, then write, then read.
- R9: With BLOCK_MODE=1, a read or write of any word acts on every word of that line.
- R10: Intervals are measured modulo 2^TS_W, so an interval that spans a wrap of the cycle counter is counted by its true length.
- R11: Events on one line leave the state of every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_i | input | 1 | Line fill strobe |
| read_i | input | 1 | Word read strobe |
| write_i | input | 1 | Word write strobe |
| evict_i | input | 1 | Line eviction strobe |
| evict_dirty_i | input | 1 | Dirty status of the line being evicted |
| line_i | input | $clog2(NUM_LINES) | Line index of the event |
| word_i | input | $clog2(WORDS_PER_LINE) | Word index for reads and writes |
| cycle_i | input | TS_W | Free-running cycle counter value |
| vuln_total_o | output | ACC_W | Accumulated vulnerability in bit-cycles |

## Verification
Two instances, one word-level and one line-level, see the same stream and are checked against a model. A read after a write of a different word of the same line separates the two modes, and so does an eviction with one dirty word. Directed cases cover an eviction with dirty status low, a read of a never-filled line, all strobes at once, and an interval that spans a counter wrap. Then several thousand random events with random gaps and occasional simultaneous strobes mix these patterns across lines, which exposes any leakage between lines.

// File: rtl/word_vuln_pkg.sv
package word_vuln_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_FILL  = 3'd3,
    OP_EVICT = 3'd4
  } op_e;
endpackage

// File: rtl/wvt_state_bank.sv
module wvt_state_bank
  import word_vuln_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int WORDS     = 4,
  parameter int TS_W      = 16,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  op_e                        op_i,
  input  logic [LINE_W-1:0]          line_i,
  input  logic [WORDS-1:0]           mask_i,
  input  logic [TS_W-1:0]            cycle_i,
  output logic [WORDS-1:0][TS_W-1:0] ts_o,
  output logic [WORDS-1:0]           dirty_o,
  output logic [WORDS-1:0]           valid_o
);
  logic [NUM_LINES-1:0][WORDS-1:0][TS_W-1:0] ts_q;
  logic [NUM_LINES-1:0][WORDS-1:0]           dirty_q;
  logic [NUM_LINES-1:0][WORDS-1:0]           valid_q;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic sel;
    assign sel = (line_i == LINE_W'(l));
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ts_q[l][w]    <= '0;
          dirty_q[l][w] <= 1'b0;
          valid_q[l][w] <= 1'b0;
        end else if (sel) begin
          unique case (op_i)
            OP_FILL: begin
              ts_q[l][w]    <= cycle_i;
              dirty_q[l][w] <= 1'b0;
              valid_q[l][w] <= 1'b1;
            end
            OP_EVICT: begin
              dirty_q[l][w] <= 1'b0;
              valid_q[l][w] <= 1'b0;
            end
            OP_WRITE: if (mask_i[w]) begin
              ts_q[l][w]    <= cycle_i;
              dirty_q[l][w] <= 1'b1;
              valid_q[l][w] <= 1'b1;
            end
            OP_READ: if (mask_i[w]) ts_q[l][w] <= cycle_i;
            default: ;
          endcase
        end
      end
    end
  end

  assign ts_o    = ts_q[line_i];
  assign dirty_o = dirty_q[line_i];
  assign valid_o = valid_q[line_i];

  AST_WRITE_MARKS_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_WRITE) |=> ((dirty_q[$past(line_i)] & $past(mask_i)) == $past(mask_i))); // R3
  AST_FILL_CLEAN_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FILL) |=> (dirty_q[$past(line_i)] == '0 && valid_q[$past(line_i)] == '1)); // R4
  AST_EVICT_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_EVICT) |=> (valid_q[$past(line_i)] == '0 && dirty_q[$past(line_i)] == '0)); // R5
endmodule

// File: rtl/wvt_delta.sv
module wvt_delta
  import word_vuln_pkg::*;
#(
  parameter int WORDS     = 4,
  parameter int TS_W      = 16,
  parameter int WORD_BITS = 32,
  parameter int DELTA_W   = 24
) (
  input  op_e                        op_i,
  input  logic                       evict_dirty_i,
  input  logic [WORDS-1:0]           mask_i,
  input  logic [TS_W-1:0]            cycle_i,
  input  logic [WORDS-1:0][TS_W-1:0] ts_i,
  input  logic [WORDS-1:0]           dirty_i,
  input  logic [WORDS-1:0]           valid_i,
  output logic [DELTA_W-1:0]         delta_o
);
  localparam logic [DELTA_W-1:0] WB = DELTA_W'(WORD_BITS);

  logic [WORDS-1:0][DELTA_W-1:0] contrib;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [TS_W-1:0] age;
    logic            take;
    assign age  = cycle_i - ts_i[w];  // wraps modulo 2^TS_W
    always_comb begin
      take = 1'b0;
      if (valid_i[w]) begin
        if (op_i == OP_READ)  take = mask_i[w];
        if (op_i == OP_EVICT) take = evict_dirty_i & dirty_i[w];
      end
    end
    assign contrib[w] = take ? DELTA_W'(age) * WB : '0;
  end

  always_comb begin
    delta_o = '0;
    for (int w = 0; w < WORDS; w++) delta_o = delta_o + contrib[w];
  end
endmodule

// File: rtl/word_vuln_tracker.sv
module word_vuln_tracker
  import word_vuln_pkg::*;
#(
  parameter int NUM_LINES      = 8,
  parameter int WORDS_PER_LINE = 4,
  parameter int WORD_BITS      = 32,
  parameter int TS_W           = 16,
  parameter int ACC_W          = 48,
  parameter bit BLOCK_MODE     = 1'b0,
  localparam int LINE_W  = $clog2(NUM_LINES),
  localparam int WORD_W  = $clog2(WORDS_PER_LINE),
  localparam int DELTA_W = TS_W + $clog2(WORD_BITS) + $clog2(WORDS_PER_LINE) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_i,
  input  logic              read_i,
  input  logic              write_i,
  input  logic              evict_i,
  input  logic              evict_dirty_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [TS_W-1:0]   cycle_i,
  output logic [ACC_W-1:0]  vuln_total_o
);
  op_e                                op;
  logic [WORDS_PER_LINE-1:0]           mask;
  logic [WORDS_PER_LINE-1:0][TS_W-1:0] ts_line;
  logic [WORDS_PER_LINE-1:0]           dirty_line;
  logic [WORDS_PER_LINE-1:0]           valid_line;
  logic [DELTA_W-1:0]                  delta;
  logic [ACC_W-1:0]                    total_q;

  always_comb begin
    if (evict_i)      op = OP_EVICT;
    else if (fill_i)  op = OP_FILL;
    else if (write_i) op = OP_WRITE;
    else if (read_i)  op = OP_READ;
    else              op = OP_NONE;
  end

  if (BLOCK_MODE) begin : g_block
    assign mask = '1;
  end else begin : g_word
    assign mask = WORDS_PER_LINE'(1) << word_i;
  end

  wvt_state_bank #(
    .NUM_LINES(NUM_LINES), .WORDS(WORDS_PER_LINE), .TS_W(TS_W)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .line_i(line_i), .mask_i(mask),
    .cycle_i(cycle_i), .ts_o(ts_line), .dirty_o(dirty_line), .valid_o(valid_line)
  );

  wvt_delta #(
    .WORDS(WORDS_PER_LINE), .TS_W(TS_W), .WORD_BITS(WORD_BITS), .DELTA_W(DELTA_W)
  ) u_delta (
    .op_i(op), .evict_dirty_i(evict_dirty_i), .mask_i(mask), .cycle_i(cycle_i),
    .ts_i(ts_line), .dirty_i(dirty_line), .valid_i(valid_line), .delta_o(delta)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) total_q <= '0;
    else         total_q <= total_q + ACC_W'(delta);
  end

  assign vuln_total_o = total_q;

  AST_WRITE_NO_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_WRITE) |=> $stable(vuln_total_o)); // R3
  AST_FILL_NO_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_FILL) |=> $stable(vuln_total_o)); // R4
  AST_CLEAN_EVICT_NO_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_i && !evict_dirty_i) |=> $stable(vuln_total_o)); // R6
  AST_INVALID_READ_NO_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_READ && (valid_line & mask) == '0) |=> $stable(vuln_total_o)); // R7
endmodule

// File: tb/word_vuln_tracker_tb.sv
module word_vuln_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int L = 8;
  localparam int W = 4;
  localparam int WB = 32;
  localparam int TSW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill = 0, rd = 0, wr = 0, ev = 0, ev_d = 0;
  logic [2:0] line = '0;
  logic [1:0] word = '0;
  logic [15:0] cyc = '0;
  logic [47:0] tot_w, tot_b;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int unsigned mts [2][L][W];
  bit          md  [2][L][W];
  bit          mv  [2][L][W];
  longint unsigned exp_tot [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  word_vuln_tracker #(.BLOCK_MODE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fill_i(fill), .read_i(rd), .write_i(wr),
    .evict_i(ev), .evict_dirty_i(ev_d), .line_i(line), .word_i(word),
    .cycle_i(cyc), .vuln_total_o(tot_w));

  word_vuln_tracker #(.BLOCK_MODE(1'b1)) dut_blk_i (
    .clk_i(clk), .rst_ni(rst_n), .fill_i(fill), .read_i(rd), .write_i(wr),
    .evict_i(ev), .evict_dirty_i(ev_d), .line_i(line), .word_i(word),
    .cycle_i(cyc), .vuln_total_o(tot_b));

  function automatic longint unsigned age_of(int unsigned c, int unsigned t);
    return longint'((c - t) & 32'hFFFF);
  endfunction

  task automatic model(int m, bit f, bit r, bit w_, bit e, bit ed, int l, int wd, int unsigned c);
    for (int w = 0; w < W; w++) begin
      bit hit = (m == 1) || (w == wd);
      if (e) begin
        if (ed && md[m][l][w] && mv[m][l][w]) exp_tot[m] += age_of(c, mts[m][l][w]) * WB;
        md[m][l][w] = 0; mv[m][l][w] = 0;
      end else if (f) begin
        mts[m][l][w] = c; md[m][l][w] = 0; mv[m][l][w] = 1;
      end else if (w_) begin
        if (hit) begin mts[m][l][w] = c; md[m][l][w] = 1; mv[m][l][w] = 1; end
      end else if (r) begin
        if (hit) begin
          if (mv[m][l][w]) exp_tot[m] += age_of(c, mts[m][l][w]) * WB;
          mts[m][l][w] = c;
        end
      end
    end
  endtask

  task automatic check(string tag);
    checks++;
    if (tot_w != exp_tot[0][47:0]) begin
      errors++;
      $display("FAIL %s word-mode: actual=%0d expected=%0d", tag, tot_w, exp_tot[0]);
    end
    checks++;
    if (tot_b != exp_tot[1][47:0]) begin
      errors++;
      $display("FAIL %s block-mode: actual=%0d expected=%0d", tag, tot_b, exp_tot[1]);
    end
  endtask

  task automatic step(bit f, bit r, bit w_, bit e, bit ed, int l, int wd, int unsigned c, string tag);
    @(negedge clk);
    fill = f; rd = r; wr = w_; ev = e; ev_d = ed;
    line = 3'(l); word = 2'(wd); cyc = 16'(c);
    model(0, f, r, w_, e, ed, l, wd, c & 32'hFFFF);
    model(1, f, r, w_, e, ed, l, wd, c & 32'hFFFF);
    @(posedge clk);
    #1;
    fill = 0; rd = 0; wr = 0; ev = 0; ev_d = 0;
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned c;
    void'($urandom(32'd4242));
    exp_tot[0] = 0; exp_tot[1] = 0;
    for (int m = 0; m < 2; m++)
      for (int l = 0; l < L; l++)
        for (int w = 0; w < W; w++) begin mts[m][l][w] = 0; md[m][l][w] = 0; mv[m][l][w] = 0; end
    repeat (3) @(posedge clk);
    #1 check("R1 reset total");
    @(negedge clk) rst_n = 1'b1;
    #1 check("R1 after release");

    // word vs block, read and dirty eviction
    step(1,0,0,0,0, 0,0, 100, "R4 fill adds nothing");
    step(0,1,0,0,0, 0,1, 110, "R2 R9 read of valid word");
    step(0,0,1,0,0, 0,2, 115, "R3 write adds nothing");
    step(0,1,0,0,0, 0,1, 118, "R2 R9 read after write in same line");
    step(0,0,0,1,1, 0,0, 130, "R5 R9 dirty eviction");
    step(0,1,0,0,0, 0,2, 140, "R5 R7 read after eviction");
    // clean eviction
    step(1,0,0,0,0, 1,0, 200, "R4 fill");
    step(0,0,1,0,0, 1,0, 205, "R3 write");
    step(0,0,0,1,0, 1,0, 220, "R6 eviction with dirty low");
    // invalid line
    step(0,1,0,0,0, 2,3, 230, "R7 read of never-filled line");
    // priority
    step(1,0,0,0,0, 3,0, 300, "R4 fill");
    step(1,1,1,1,1, 3,0, 310, "R8 evict wins over all");
    step(0,1,0,0,0, 3,0, 320, "R8 line invalid after evict");
    step(1,0,0,0,0, 4,0, 400, "R4 fill");
    step(0,1,1,0,0, 4,0, 410, "R8 write wins over read");
    step(0,1,0,0,0, 4,0, 415, "R8 interval restarted by write");
    // wrap
    step(1,0,0,0,0, 5,0, 65530, "R4 fill near wrap");
    step(0,1,0,0,0, 5,3, 65540, "R10 interval across wrap");
    // line independence
    step(1,0,0,0,0, 6,0, 500, "R4 fill");
    step(1,0,0,0,0, 7,0, 600, "R4 fill other line");
    step(0,1,0,0,0, 6,0, 610, "R11 other line untouched");

    c = 700;
    for (int i = 0; i < 4000; i++) begin
      int unsigned k = $urandom % 100;
      bit f = 0, r = 0, w_ = 0, e = 0;
      c += 1 + (($urandom % 20 == 0) ? ($urandom % 3000) : ($urandom % 6));
      if (k < 8) begin f = 1; r = $urandom % 2; w_ = $urandom % 2; e = $urandom % 2; end
      else if (k < 18) f = 1;
      else if (k < 26) e = 1;
      else if (k < 56) w_ = 1;
      else r = 1;
      step(f, r, w_, e, $urandom % 2, int'($urandom % L), int'($urandom % W), c,
           "R2 R3 R5 R11 random mix");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule